// File: doc/BRIEF.md
# Ping-Pong Configuration Bank Selector

A frame-based pipeline reads its settings from one of two register banks, ping or pong, while the host prepares the other bank. This block decides which bank the pipeline uses and keeps track of which banks are still in use by frames in flight. It also filters host writes so that a bank a frame depends on is never modified. The register storage sits outside the block. The block drives per-bank write enables, together with a registered copy of the address and data, into that storage.

In automatic mode the block swaps banks at every accepted frame start, as long as the other bank is free. In override mode the host picks the bank with a select bit. Changes to that bit take effect only while no frame is in flight, or at the next accepted frame start. A small in-flight queue records the bank of each frame between its first pixel entering and its last pixel leaving. A bank is locked while any queued frame uses it. A host write aimed at a locked bank is dropped and raises a one-cycle context error.

Top module: `ppctx_selector`

## Requirements
- R1: While reset is high and in the first cycle after it, `sel_o` is 0 (pong), `stat_o` is 0, `bank_wr_o` is 0 and `ctx_err_o` is 0.
- R2: With `ovr_en_i` low, an accepted frame start swaps the in-use bank. If the other bank is locked in that cycle, the in-use bank stays where it is. The new value shows on `sel_o` in the next cycle.
- R3: With `ovr_en_i` high, an accepted frame start loads `ovr_sel_i` (1 = ping, 0 = pong) into `sel_o`. With no frame in flight and no start, `sel_o` follows `ovr_sel_i` one cycle later. While any frame is in flight, `sel_o` changes only at an accepted frame start.
- R4: An accepted frame start enqueues the bank chosen for that frame, which locks it from the next cycle on. `frm_end_i` removes the oldest in-flight frame. A bank stays locked while any queued frame uses it.
- R5: At most DEPTH frames (default 2) are in flight. A start while the queue is full and no end arrives in the same cycle is ignored. An end arriving with no frame in flight is ignored. A start and an end in the same cycle are both taken, the end first.
- R6: A host write (`hwr_i`, `hwr_bank_i` 1 = ping, 0 = pong) to a bank that is unlocked in the request cycle raises exactly one enable in the next cycle. Bit 0 of `bank_wr_o` is ping and bit 1 is pong. The request's address and data appear on `bank_addr_o` and `bank_data_o` in that same cycle.
- R7: A host write to a bank that is locked in the request cycle raises no enable and produces a one-cycle `ctx_err_o` pulse in the next cycle.
- R8: `stat_o` bit 0 is the ping lock, bit 1 is the pong lock, and bit 2 is the in-use bank (1 = ping). `sel_o` equals bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start_i | input | 1 | First pixel of a frame leaves the input stage |
| frm_end_i | input | 1 | Last pixel of a frame leaves the pipeline output |
| ovr_en_i | input | 1 | Host takes control of the bank choice |
| ovr_sel_i | input | 1 | Host bank choice, 1 = ping, 0 = pong |
| hwr_i | input | 1 | Host write request |
| hwr_bank_i | input | 1 | Target bank of the write, 1 = ping, 0 = pong |
| hwr_addr_i | input | ADDR_W | Write address |
| hwr_data_i | input | DATA_W | Write data |
| sel_o | output | 1 | Bank in use, 1 = ping, 0 = pong |
| stat_o | output | 3 | {in-use bank, pong locked, ping locked} |
| bank_wr_o | output | 2 | Write enables, bit 0 ping, bit 1 pong |
| bank_addr_o | output | ADDR_W | Registered write address |
| bank_data_o | output | DATA_W | Registered write data |
| ctx_err_o | output | 1 | Pulse for a write rejected by a lock |

## Verification
The assertions assume that frame events and host writes are single-cycle, synchronous levels sampled at the clock edge. They also assume that lock state seen on `stat_o` in a request cycle is what decides a write. The stimulus drives every input just after the falling edge and holds it for a whole cycle. Directed phases cover queue overflow, an end with nothing in flight, a start and an end in the same cycle while the other bank is locked, and override changes during and outside frames. A long random phase then mixes all inputs with both modes.

// File: rtl/ppctx_pkg.sv
package ppctx_pkg;
  // bank encoding shared by select, status and write request
  localparam logic BANK_PONG = 1'b0;
  localparam logic BANK_PING = 1'b1;
  // index of each bank in lock and write-enable vectors
  localparam int IDX_PING = 0;
  localparam int IDX_PONG = 1;
  localparam int NUM_BANKS = 2;

  // lock state of the named bank
  function automatic logic bank_locked(input logic bank, input logic [NUM_BANKS-1:0] lk);
    return (bank == BANK_PING) ? lk[IDX_PING] : lk[IDX_PONG];
  endfunction
endpackage

// File: rtl/ppctx_inflight.sv
module ppctx_inflight #(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       end_i,
  input  logic       bank_i,
  output logic       accept_o,
  output logic [1:0] lock_o,
  output logic       idle_o
);
  import ppctx_pkg::*;

  logic [DEPTH-1:0] bnk_q, vld_q, bnk_d, vld_d;
  logic [DEPTH-1:0] hit_ping, hit_pong;
  logic pop, placed;

  assign pop      = end_i & vld_q[0];
  assign accept_o = start_i & (~vld_q[DEPTH-1] | pop);

  always_comb begin
    bnk_d  = bnk_q;
    vld_d  = vld_q;
    placed = 1'b0;
    if (pop) begin
      bnk_d = bnk_q >> 1;
      vld_d = vld_q >> 1;
    end
    if (accept_o) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!vld_d[i] && !placed) begin
          bnk_d[i] = bank_i;
          vld_d[i] = 1'b1;
          placed   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bnk_q <= '0;
      vld_q <= '0;
    end else begin
      bnk_q <= bnk_d;
      vld_q <= vld_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      assign hit_ping[g] = vld_q[g] & (bnk_q[g] == BANK_PING);
      assign hit_pong[g] = vld_q[g] & (bnk_q[g] == BANK_PONG);
    end
  endgenerate

  assign lock_o[IDX_PING] = |hit_ping;
  assign lock_o[IDX_PONG] = |hit_pong;
  assign idle_o = ~vld_q[0];
endmodule

// File: rtl/ppctx_bank_sel.sv
module ppctx_bank_sel (
  input  logic       clk,
  input  logic       rst,
  input  logic       accept_i,
  input  logic       idle_i,
  input  logic       ovr_en_i,
  input  logic       ovr_sel_i,
  input  logic [1:0] lock_i,
  output logic       sel_o,
  output logic       sel_next_o
);
  import ppctx_pkg::*;

  logic sel_q, sel_d, other_busy;

  assign other_busy = bank_locked(~sel_q, lock_i);

  always_comb begin
    sel_d = sel_q;
    if (accept_i) begin
      if (ovr_en_i)        sel_d = ovr_sel_i;
      else if (!other_busy) sel_d = ~sel_q;
    end else if (ovr_en_i && idle_i) begin
      sel_d = ovr_sel_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= BANK_PONG;
    else     sel_q <= sel_d;
  end

  assign sel_o      = sel_q;
  assign sel_next_o = sel_d;
endmodule

// File: rtl/ppctx_wr_gate.sv
module ppctx_wr_gate #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        lock_i,
  output logic [1:0]        wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  import ppctx_pkg::*;

  logic blocked, pass;
  assign blocked = bank_locked(bank_i, lock_i);
  assign pass    = req_i & ~blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_o  <= '0;
      err_o <= 1'b0;
    end else begin
      wr_o[IDX_PING] <= pass & (bank_i == BANK_PING);
      wr_o[IDX_PONG] <= pass & (bank_i == BANK_PONG);
      err_o          <= req_i & blocked;
    end
  end

  // data path without reset so it maps onto plain enable flops
  always_ff @(posedge clk) begin
    if (pass) begin
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/ppctx_selector.sv
module ppctx_selector #(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start_i,
  input  logic              frm_end_i,
  input  logic              ovr_en_i,
  input  logic              ovr_sel_i,
  input  logic              hwr_i,
  input  logic              hwr_bank_i,
  input  logic [ADDR_W-1:0] hwr_addr_i,
  input  logic [DATA_W-1:0] hwr_data_i,
  output logic              sel_o,
  output logic [2:0]        stat_o,
  output logic [1:0]        bank_wr_o,
  output logic [ADDR_W-1:0] bank_addr_o,
  output logic [DATA_W-1:0] bank_data_o,
  output logic              ctx_err_o
);
  logic       accept, idle, sel_next;
  logic [1:0] lock;

  ppctx_inflight #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .start_i(frm_start_i), .end_i(frm_end_i),
    .bank_i(sel_next), .accept_o(accept), .lock_o(lock), .idle_o(idle)
  );

  ppctx_bank_sel u_sel (
    .clk(clk), .rst(rst), .accept_i(accept), .idle_i(idle),
    .ovr_en_i(ovr_en_i), .ovr_sel_i(ovr_sel_i), .lock_i(lock),
    .sel_o(sel_o), .sel_next_o(sel_next)
  );

  ppctx_wr_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst), .req_i(hwr_i), .bank_i(hwr_bank_i),
    .addr_i(hwr_addr_i), .data_i(hwr_data_i), .lock_i(lock),
    .wr_o(bank_wr_o), .addr_o(bank_addr_o), .data_o(bank_data_o), .err_o(ctx_err_o)
  );

  assign stat_o = {sel_o, lock};
endmodule

// File: rtl/ppctx_chk.sv
module ppctx_chk (
  input logic       clk,
  input logic       rst,
  input logic       frm_start_i,
  input logic       ovr_en_i,
  input logic       ovr_sel_i,
  input logic       hwr_i,
  input logic       hwr_bank_i,
  input logic       sel_o,
  input logic [2:0] stat_o,
  input logic [1:0] bank_wr_o,
  input logic       ctx_err_o
);
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_wr_o));  // R6

  AST_LOCKED_REJECT: assert property (@(posedge clk) disable iff (rst)
    (hwr_i && (hwr_bank_i ? stat_o[0] : stat_o[1])) |=> (ctx_err_o && bank_wr_o == 2'b00));  // R7

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ctx_err_o |-> $past(hwr_i));  // R7

  AST_SEL_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!frm_start_i && stat_o[1:0] != 2'b00) |=> $stable(sel_o));  // R3

  AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (ovr_en_i && !frm_start_i && stat_o[1:0] == 2'b00) |=> (sel_o == $past(ovr_sel_i)));  // R3
endmodule

bind ppctx_selector ppctx_chk u_chk (
  .clk(clk), .rst(rst), .frm_start_i(frm_start_i), .ovr_en_i(ovr_en_i),
  .ovr_sel_i(ovr_sel_i), .hwr_i(hwr_i), .hwr_bank_i(hwr_bank_i),
  .sel_o(sel_o), .stat_o(stat_o), .bank_wr_o(bank_wr_o), .ctx_err_o(ctx_err_o)
);

// File: tb/sim_ppctx_selector.sv
module sim_ppctx_selector;
  localparam int DEPTH = 2;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_start = 0, frm_end = 0, ovr_en = 0, ovr_sel = 0, hwr = 0, hwr_bank = 0;
  logic [AW-1:0] hwr_addr = '0;
  logic [DW-1:0] hwr_data = '0;
  logic sel;
  logic [2:0] stat;
  logic [1:0] wr;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;
  logic err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ppctx_selector #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .frm_start_i(frm_start), .frm_end_i(frm_end),
    .ovr_en_i(ovr_en), .ovr_sel_i(ovr_sel), .hwr_i(hwr), .hwr_bank_i(hwr_bank),
    .hwr_addr_i(hwr_addr), .hwr_data_i(hwr_data), .sel_o(sel), .stat_o(stat),
    .bank_wr_o(wr), .bank_addr_o(waddr), .bank_data_o(wdata), .ctx_err_o(err)
  );

  // behavioural reference model
  bit q[$];
  bit m_sel = 0;
  bit [1:0] m_wr = 0;
  bit m_err = 0;
  bit [AW-1:0] m_addr;
  bit [DW-1:0] m_data;

  function automatic bit used(bit b);
    foreach (q[i]) if (q[i] == b) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_sel = 0; m_wr = 0; m_err = 0;
    end else begin
      bit lk_ping, lk_pong, blk, pop, push, nsel;
      lk_ping = used(1);
      lk_pong = used(0);
      blk = hwr_bank ? lk_ping : lk_pong;
      m_wr = 0; m_err = 0;
      if (hwr) begin
        if (blk) m_err = 1;
        else begin
          if (hwr_bank) m_wr[0] = 1; else m_wr[1] = 1;
          m_addr = hwr_addr; m_data = hwr_data;
        end
      end
      pop  = frm_end && q.size() > 0;
      push = frm_start && (q.size() < DEPTH || pop);
      nsel = m_sel;
      if (push) begin
        if (ovr_en) nsel = ovr_sel;
        else if (!(m_sel ? lk_pong : lk_ping)) nsel = ~m_sel;
      end else if (ovr_en && q.size() == 0) nsel = ovr_sel;
      if (pop) void'(q.pop_front());
      if (push) q.push_back(nsel);
      m_sel = nsel;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit [2:0] es;
      es = {m_sel, used(0), used(1)};
      chk(stat == es, "R2 R3 R4 R8 stat_o", stat, es);
      chk(sel == m_sel, "R8 sel_o", sel, m_sel);
      chk(wr == m_wr, "R6 R7 bank_wr_o", wr, m_wr);
      chk(err == m_err, "R7 ctx_err_o", err, m_err);
      if (m_wr != 0) begin
        chk(waddr == m_addr, "R6 bank_addr_o", waddr, m_addr);
        chk(wdata == m_data, "R6 bank_data_o", wdata, m_data);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic start_f();
    frm_start = 1; tick(); frm_start = 0;
  endtask
  task automatic end_f();
    frm_end = 1; tick(); frm_end = 0;
  endtask
  task automatic write(bit b, bit [AW-1:0] a, bit [DW-1:0] d);
    hwr = 1; hwr_bank = b; hwr_addr = a; hwr_data = d; tick(); hwr = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1: reset values while in reset
    chk(sel == 0 && stat == 0 && wr == 0 && err == 0, "R1 reset state", {sel, stat, wr, err}, 0);
    rst = 0;
    tick();
    chk(sel == 0 && stat == 0 && wr == 0 && err == 0, "R1 after reset", {sel, stat, wr, err}, 0);

    // R2: automatic swapping on separate frames
    for (int k = 0; k < 3; k++) begin
      start_f(); tick(3); end_f(); tick(2);
    end
    chk(sel == 1, "R2 three swaps from pong", sel, 1);

    // R5: overlap, overflow and stray end
    start_f(); tick(); start_f(); tick();
    chk(stat[1:0] == 2'b11, "R4 both banks locked", stat[1:0], 2'b11);
    start_f();
    chk(stat[1:0] == 2'b11, "R5 start while full ignored", stat[1:0], 2'b11);
    // R2: start with end while the other bank is still locked
    frm_start = 1; frm_end = 1; tick(); frm_start = 0; frm_end = 0;
    end_f(); end_f(); end_f(); tick();
    chk(stat[1:0] == 2'b00, "R5 queue drained, stray end ignored", stat[1:0], 0);

    // R6 / R7: writes against locks
    write(1, 10'h011, 32'h1111_0000);
    write(0, 10'h022, 32'h2222_0000);
    start_f();
    write(sel, 10'h033, 32'h3333_0000);
    write(~sel, 10'h044, 32'h4444_0000);
    end_f(); tick();

    // R3: override mode
    ovr_en = 1; ovr_sel = 1; tick(2);
    chk(sel == 1, "R3 idle follows host ping", sel, 1);
    ovr_sel = 0; tick(2);
    chk(sel == 0, "R3 idle follows host pong", sel, 0);
    ovr_sel = 1; start_f();
    ovr_sel = 0; tick(3);
    chk(sel == 1, "R3 change deferred while busy", sel, 1);
    end_f(); tick(2);
    chk(sel == 0, "R3 change applied after frame", sel, 0);
    ovr_en = 0; tick(2);

    // random mix of all inputs
    for (int k = 0; k < 4000; k++) begin
      frm_start = ($urandom_range(0, 9) < 3);
      frm_end   = ($urandom_range(0, 9) < 3);
      if ((k % 500) == 0) ovr_en = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) ovr_sel = ~ovr_sel;
      hwr = ($urandom_range(0, 9) < 4);
      hwr_bank = $urandom_range(0, 1);
      hwr_addr = AW'($urandom);
      hwr_data = $urandom;
      tick();
    end
    frm_start = 0; frm_end = 0; hwr = 0;
    tick(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule